// File: doc/BRIEF.md
# ALU Status Flag Register

This block produces and holds the status byte of an 8-bit processor core. Each cycle the core presents the two ALU operands and a 3-bit operation code. When the update strobe is high, the block derives the arithmetic flags from those operands and latches them. The flags are carry, half (nibble) carry, zero and signed overflow. The operation code selects which of these flags the operation is allowed to change.

The same byte also carries two sticky system flags. The power-down flag reports that the core entered halt. The time-out flag reports that the watchdog expired. Each changes only on its own event pulses or on the asynchronous power-up reset. Software can overwrite the four arithmetic flags through a write port. The system flags are protected from that write.

All flags are registered. The effect of any input sampled on a rising clock edge appears on `status_o` right after that edge.

Top module: `status_flag_reg`

## Requirements
- R1: The status byte layout is bit 0 carry (C), bit 1 half carry (AC), bit 2 zero (Z), bit 3 overflow (OV), bit 4 power-down (PDF), bit 5 time-out (TO). Bits 7 and 6 always read 0.
- R2: An update with op 0 (add, a+b) sets C to the carry out of bit 7 and AC to the carry out of bit 3. Each is cleared otherwise.
- R3: An update with op 1 (subtract, a-b) sets C when a >= b unsigned, meaning no borrow. It sets AC when a[3:0] >= b[3:0], meaning no borrow from the upper nibble. Each is cleared otherwise.
- R4: Z is set when the 8-bit result of an add, subtract or logic operation is zero, and cleared otherwise.
- R5: For add and subtract, OV is set when the carry into bit 7 differs from the carry out of bit 7, which is signed overflow. It is cleared otherwise.
- R6: Ops 2, 3 and 4 (a AND b, a OR b, a XOR b) update only Z. C, AC and OV keep their values.
- R7: Op 5 (rotate left through carry) loads C with a[7]. Op 6 (rotate right through carry) loads C with a[0]. Both leave AC, Z and OV unchanged.
- R8: Without an update strobe, or with op 7, the arithmetic flags hold their values.
- R9: A software write loads bits 3:0 from wr_data_i[3:0] and leaves PDF and TO unchanged. When a write and an update strobe arrive in the same cycle, the write wins.
- R10: A halt pulse sets PDF. A watchdog-clear pulse clears PDF. Halt takes priority.
- R11: A watchdog time-out pulse sets TO. A halt or watchdog-clear pulse clears TO. The time-out takes priority.
- R12: The power-up reset clears the whole status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| a_i | input | 8 | First ALU operand |
| b_i | input | 8 | Second ALU operand |
| op_i | input | 3 | Operation class code (0 add, 1 sub, 2 and, 3 or, 4 xor, 5 rotate left, 6 rotate right, 7 none) |
| upd_i | input | 1 | Flag update strobe |
| wr_en_i | input | 1 | Software write enable for the status register |
| wr_data_i | input | 8 | Software write data; only bits 3:0 are used |
| halt_i | input | 1 | Halt event pulse |
| wdt_clr_i | input | 1 | Watchdog-clear event pulse |
| wdt_to_i | input | 1 | Watchdog time-out event pulse |
| status_o | output | 8 | Status byte |

## Verification
Every flag is a register that feeds `status_o` directly. A wrong carry chain, a wrong nibble boundary or a wrong flag mask therefore shows up on the byte in the cycle right after the offending update. A flag that is overwritten when it should be kept has the same visibility. A flag that drifts without a strobe or event is caught on the first following cycle, because the bench compares the full byte every clock. Sticky-flag errors stay visible until the next event, so their priority rules are exercised with overlapping pulses.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_RLC  = 3'd5,
    OP_RRC  = 3'd6,
    OP_NONE = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic ov;
    logic z;
    logic ac;
    logic c;
  } arith_flags_t;

  typedef struct packed {
    logic to;
    logic pdf;
  } sys_flags_t;
endpackage

// File: rtl/arith_flag_gen.sv
module arith_flag_gen
  import sfr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic          sub_i,
  output arith_flags_t  flags_o
);
  localparam int unsigned H = W / 2;

  logic [W-1:0] b_eff;
  logic [W:0]   full_sum;
  logic [H:0]   low_sum;
  logic         carry_into_msb;

  // subtract as a + ~b + 1 so carry out means "no borrow"
  assign b_eff    = sub_i ? ~b_i : b_i;
  assign full_sum = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
  assign low_sum  = {1'b0, a_i[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, sub_i};
  assign carry_into_msb = a_i[W-1] ^ b_eff[W-1] ^ full_sum[W-1];

  assign flags_o.c  = full_sum[W];
  assign flags_o.ac = low_sum[H];
  assign flags_o.z  = ~|full_sum[W-1:0];
  assign flags_o.ov = carry_into_msb ^ full_sum[W];
endmodule

// File: rtl/logic_zero.sv
module logic_zero
  import sfr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic         z_o
);
  logic [W-1:0] res;

  always_comb begin
    case (op_i)
      OP_AND:  res = a_i & b_i;
      OP_OR:   res = a_i | b_i;
      OP_XOR:  res = a_i ^ b_i;
      default: res = '0;
    endcase
  end

  assign z_o = ~|res;
endmodule

// File: rtl/sys_flag_reg.sv
module sys_flag_reg
  import sfr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       halt_i,
  input  logic       wdt_clr_i,
  input  logic       wdt_to_i,
  output sys_flags_t sys_o
);
  sys_flags_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else begin
      if (halt_i)         q.pdf <= 1'b1;
      else if (wdt_clr_i) q.pdf <= 1'b0;

      if (wdt_to_i)                 q.to <= 1'b1;
      else if (halt_i || wdt_clr_i) q.to <= 1'b0;
    end
  end

  assign sys_o = q;
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
  import sfr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [2:0]        op_i,
  input  logic              upd_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_data_i,
  input  logic              halt_i,
  input  logic              wdt_clr_i,
  input  logic              wdt_to_i,
  output logic [7:0]        status_o
);
  localparam int unsigned AF_W = $bits(arith_flags_t);

  alu_op_e      op;
  arith_flags_t arith_new;
  arith_flags_t af_q, af_d;
  sys_flags_t   sys;
  logic         logic_z;
  logic         unused_wr_hi;

  assign op           = alu_op_e'(op_i);
  assign unused_wr_hi = ^wr_data_i[7:AF_W];

  arith_flag_gen #(.W(DATA_W)) u_arith (
    .a_i     (a_i),
    .b_i     (b_i),
    .sub_i   (op == OP_SUB),
    .flags_o (arith_new)
  );

  logic_zero #(.W(DATA_W)) u_lzero (
    .a_i  (a_i),
    .b_i  (b_i),
    .op_i (op),
    .z_o  (logic_z)
  );

  sys_flag_reg u_sys (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .halt_i    (halt_i),
    .wdt_clr_i (wdt_clr_i),
    .wdt_to_i  (wdt_to_i),
    .sys_o     (sys)
  );

  always_comb begin
    af_d = af_q;
    if (upd_i) begin
      case (op)
        OP_ADD, OP_SUB:         af_d = arith_new;
        OP_AND, OP_OR, OP_XOR:  af_d.z = logic_z;
        OP_RLC:                 af_d.c = a_i[DATA_W-1];
        OP_RRC:                 af_d.c = a_i[0];
        default:                ;
      endcase
    end
    // software write overrides any same-cycle update
    if (wr_en_i) af_d = arith_flags_t'(wr_data_i[AF_W-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) af_q <= '0;
    else         af_q <= af_d;
  end

  assign status_o = {2'b00, sys.to, sys.pdf, af_q.ov, af_q.z, af_q.ac, af_q.c};
endmodule

// File: rtl/status_flag_reg_chk.sv
module status_flag_reg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] op_i,
  input logic       upd_i,
  input logic       wr_en_i,
  input logic [3:0] wr_data_i,
  input logic       halt_i,
  input logic       wdt_clr_i,
  input logic       wdt_to_i,
  input logic [7:0] status_o
);
  logic is_logic, is_rot;
  assign is_logic = (op_i == 3'd2) || (op_i == 3'd3) || (op_i == 3'd4);
  assign is_rot   = (op_i == 3'd5) || (op_i == 3'd6);

  assert_rsvd_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7:6] == 2'b00);

  assert_logic_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && !wr_en_i && is_logic |=> $stable(status_o[1:0]) && $stable(status_o[3]));

  assert_rot_keeps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && !wr_en_i && is_rot |=> $stable(status_o[3:1]));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i || op_i == 3'd7) && !wr_en_i |=> $stable(status_o[3:0]));

  assert_wr_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> status_o[3:0] == $past(wr_data_i));

  assert_pdf_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> status_o[4]);

  assert_to_set_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_to_i |=> status_o[5]);

  assert_sys_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halt_i && !wdt_clr_i && !wdt_to_i |=> $stable(status_o[5:4]));
endmodule

bind status_flag_reg status_flag_reg_chk chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .op_i      (op_i),
  .upd_i     (upd_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i[3:0]),
  .halt_i    (halt_i),
  .wdt_clr_i (wdt_clr_i),
  .wdt_to_i  (wdt_to_i),
  .status_o  (status_o)
);

// File: tb/status_flag_reg_tb_top.sv
module status_flag_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] a_i = '0, b_i = '0, wr_data_i = '0;
  logic [2:0] op_i = 3'd7;
  logic       upd_i = 1'b0, wr_en_i = 1'b0;
  logic       halt_i = 1'b0, wdt_clr_i = 1'b0, wdt_to_i = 1'b0;
  logic [7:0] status_o;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_q = '0;

  always #5 clk = ~clk;

  status_flag_reg dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .op_i(op_i),
    .upd_i(upd_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .halt_i(halt_i), .wdt_clr_i(wdt_clr_i), .wdt_to_i(wdt_to_i),
    .status_o(status_o)
  );

  // behavioural reference: next status byte from current byte and inputs
  function automatic logic [7:0] model(logic [7:0] cur, int a, int b, int op,
                                       bit upd, bit wr, int wd, bit hlt, bit clr, bit tmo);
    int c = cur[0], ac = cur[1], z = cur[2], ov = cur[3], pdf = cur[4], to = cur[5];
    int res;
    if (upd) begin
      case (op)
        0: begin
          res = (a + b) % 256;
          c  = (a + b) > 255;
          ac = ((a % 16) + (b % 16)) > 15;
          z  = (res == 0);
          ov = (a / 128 == b / 128) && (res / 128 != a / 128);
        end
        1: begin
          res = (a - b + 256) % 256;
          c  = a >= b;
          ac = (a % 16) >= (b % 16);
          z  = (res == 0);
          ov = (a / 128 != b / 128) && (res / 128 != a / 128);
        end
        2: z = ((a & b) == 0);
        3: z = ((a | b) == 0);
        4: z = ((a ^ b) == 0);
        5: c = a / 128;
        6: c = a % 2;
        default: ;
      endcase
    end
    if (wr) begin
      c = wd % 2; ac = (wd / 2) % 2; z = (wd / 4) % 2; ov = (wd / 8) % 2;
    end
    if (hlt) pdf = 1; else if (clr) pdf = 0;
    if (tmo) to = 1; else if (hlt || clr) to = 0;
    return 8'((to << 5) | (pdf << 4) | (ov << 3) | (z << 2) | (ac << 1) | c);
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // drive at negedge, model the next edge, compare at following negedge
  task automatic step(string tag, int a, int b, int op, bit upd,
                      bit wr = 0, int wd = 0, bit hlt = 0, bit clr = 0, bit tmo = 0);
    a_i = 8'(a); b_i = 8'(b); op_i = 3'(op); upd_i = upd;
    wr_en_i = wr; wr_data_i = 8'(wd); halt_i = hlt; wdt_clr_i = clr; wdt_to_i = tmo;
    exp_q = model(exp_q, a, b, op, upd, wr, wd, hlt, clr, tmo);
    @(negedge clk);
    check(tag, status_o, exp_q);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 reset", status_o, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R12 after release", status_o, 8'h00);

    step("R2 add nibble carry", 8'h0F, 8'h01, 0, 1);
    step("R2 add carry out / R4 zero", 8'hFF, 8'h01, 0, 1);
    step("R5 add overflow", 8'h7F, 8'h01, 0, 1);
    step("R5 add neg overflow", 8'h80, 8'h80, 0, 1);
    step("R3 sub no borrow", 8'h05, 8'h03, 1, 1);
    step("R3 sub borrow", 8'h03, 8'h05, 1, 1);
    step("R3 sub nibble borrow", 8'h10, 8'h01, 1, 1);
    step("R5 sub overflow", 8'h80, 8'h01, 1, 1);
    step("R4 sub zero", 8'h42, 8'h42, 1, 1);
    step("R6 and zero keeps others", 8'hF0, 8'h0F, 2, 1);
    step("R6 or nonzero", 8'h00, 8'h01, 3, 1);
    step("R6 xor zero", 8'h5A, 8'h5A, 4, 1);
    step("R7 rotate left C", 8'h80, 8'h00, 5, 1);
    step("R7 rotate right C", 8'h02, 8'h00, 6, 1);
    step("R7 rotate right C set", 8'h01, 8'h00, 6, 1);
    step("R8 no strobe", 8'h00, 8'h00, 0, 0);
    step("R8 op none", 8'h00, 8'h00, 7, 1);
    step("R9 write wins over add", 8'hFF, 8'h01, 0, 1, 1, 8'h0A);
    step("R9 write high bits ignored / R1", 8'h00, 8'h00, 7, 0, 1, 8'hF5);
    step("R10 halt sets PDF", 0, 0, 7, 0, 0, 0, 1);
    step("R11 timeout sets TO", 0, 0, 7, 0, 0, 0, 0, 0, 1);
    step("R9 write keeps PDF TO", 0, 0, 7, 0, 1, 8'hFF);
    step("R11 halt clears TO", 0, 0, 7, 0, 0, 0, 1);
    step("R11 timeout beats clear", 0, 0, 7, 0, 0, 0, 0, 1, 1);
    step("R10 clear drops PDF", 0, 0, 7, 0, 0, 0, 0, 1);
    step("R10 halt beats clear", 0, 0, 7, 0, 0, 0, 1, 1);
    step("R1 reserved bits", 0, 0, 7, 0, 1, 8'hFF, 0, 0, 1);
    check("R1 bits 7:6", {6'd0, status_o[7:6]}, 8'h00);

    for (int i = 0; i < 3000; i++) begin
      int op = $urandom_range(0, 7);
      bit wr = ($urandom_range(0, 7) == 0);
      string tag = wr ? "R9 random" : (op < 2 ? "R2 random" : (op < 5 ? "R6 random" : "R7 random"));
      step(tag, $urandom_range(0, 255), $urandom_range(0, 255), op,
           ($urandom_range(0, 3) != 0), wr, $urandom_range(0, 255),
           ($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0),
           ($urandom_range(0, 15) == 0));
    end

    rst_ni = 1'b0;
    #1;
    exp_q = '0;
    check("R12 async reset", status_o, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule